// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor

This block is a small processor whose entire control behaviour is held in a read-only microcode store of 128 words of 20 bits. A sequencer forms the next control address every clock. It chooses among an increment, a jump or call target carried in the microword, a return address held in a one-deep return register, and an opcode-derived routine address. The word read at that address is captured in a control data register. Its three micro-operation fields then drive an accumulator datapath with four registers (AC, DR, AR, PC) and a 2048-word, 16-bit main memory. The next address is formed while those micro-operations execute.

Machine instructions are 16 bits wide. Bit 15 is the indirect flag, bits 14..11 are the opcode and bits 10..0 are the memory address. The microprogram provides a shared instruction-fetch routine and a shared indirect-address routine, both in the upper half of the control store. It also provides four instruction routines, each with four control words per opcode: ADD (opcode 0), conditional BRANCH (opcode 1), STORE (opcode 2) and EXCHANGE (opcode 3). A test preload port fills main memory while the processor is held in reset. AC, PC and the control address are brought out for observation.

Top module: `ucode_accum_cpu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, AC and PC become 0 and the control address becomes 64, the first word of the fetch routine. After release, execution starts by fetching the instruction at memory address 0.
- R2: An instruction is decoded as bit 15 = indirect flag, bits 14..11 = opcode, bits 10..0 = address. The fetch routine's mapping step sends control to address {0, opcode, 00}, so opcode 0 goes to 0, opcode 1 to 4, opcode 2 to 8 and opcode 3 to 12.
- R3: ADD (opcode 0) sets AC to (AC + M[EA]) mod 2^16. Each fetch advances PC by one.
- R4: With the indirect flag set, the effective address EA is bits 10..0 of M[address], and bits 15..11 of that pointer word are ignored. With the flag clear, EA is the address field.
- R5: BRANCH (opcode 1) loads PC with EA when AC bit 15 is 1. Otherwise PC keeps its post-fetch value, and a zero AC counts as not negative. AC is unchanged in both cases.
- R6: STORE (opcode 2) writes AC to M[EA] and leaves AC unchanged.
- R7: EXCHANGE (opcode 3) loads AC with the old M[EA] and writes the old AC to M[EA].
- R8: Opcodes 4 to 15 change neither AC nor memory, whatever their indirect flag. They only advance PC by one.
- R9: A taken CALL saves the control address plus one in the return register and jumps to the microword's target. RET resumes at the saved address. A CALL whose condition is false continues at the next control address.
- R10: One microword executes per clock, so instructions take a fixed number of cycles from one fetch start (control address 64) to the next. ADD takes 6, STORE 6 and EXCHANGE 7, each plus 2 when the indirect flag is set. A taken BRANCH takes 6 (8 when indirect), a BRANCH not taken takes 5, and opcodes 4 to 15 take 4.
- R11: When `pre_we` is high at a rising edge, `pre_data` is written to the memory word at `pre_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_we | input | 1 | Memory preload write enable |
| pre_addr | input | 11 | Memory preload word address |
| pre_data | input | 16 | Memory preload data |
| ac_o | output | 16 | Accumulator value |
| pc_o | output | 11 | Program counter value |
| car_o | output | 7 | Control address of the microword now executing |

## Verification
The hardest path to reach from the ports is the taken indirect BRANCH. Control must pass the sign test, make a nested call into the indirect routine, return into the middle of the branch routine and only then load PC. The sign is set only by earlier ADD instructions, so each branch test first adds a chosen value (0x8000, 0x7FFF, 0xFFFF, 0x0000) from memory into the freshly cleared accumulator. The branch is then run directly and through a pointer whose upper bits are non-zero. The memory side effects of STORE and EXCHANGE are made visible by exchanging the same word back into AC twice. Memory left untouched by the unimplemented opcodes is brought out the same way.

// File: rtl/ucpu_pkg.sv
// Shared constants and types of the microprogrammed accumulator processor.
// Assumes the 16-bit instruction and 20-bit microword layouts below are fixed.
package ucpu_pkg;

    localparam int WORD_W = 16;                 // data and instruction width
    localparam int ADDR_W = 11;                 // main memory address width
    localparam int OPC_W  = 4;                  // opcode field width
    localparam int CA_W   = 7;                  // control address width
    localparam int MEM_WORDS = 1 << ADDR_W;     // main memory depth
    localparam int CS_WORDS  = 1 << CA_W;       // control store depth
    localparam int OPC_LSB   = ADDR_W;          // opcode field position

    localparam logic [CA_W-1:0] FETCH_ENTRY = CA_W'(CS_WORDS / 2);
    localparam logic [CA_W-1:0] INDIR_ENTRY = CA_W'(CS_WORDS / 2 + 3);

    // First micro-operation field: accumulator and address register loads, write.
    typedef enum logic [2:0] {
        F1_NONE, F1_SUM, F1_ZERO_AC, F1_INC_AC,
        F1_DR_TO_AC, F1_DR_TO_AR, F1_PC_TO_AR, F1_STORE
    } f1_e;

    // Second micro-operation field: logic ops and data register loads.
    typedef enum logic [2:0] {
        F2_NONE, F2_DIFF, F2_OR, F2_AND,
        F2_LOAD, F2_AC_TO_DR, F2_INC_DR, F2_PC_TO_DR
    } f2_e;

    // Third micro-operation field: shifts, complement and program counter loads.
    typedef enum logic [2:0] {
        F3_NONE, F3_XOR, F3_INV, F3_SHL,
        F3_SHR, F3_INC_PC, F3_AR_TO_PC, F3_SPARE
    } f3_e;

    // Status bit tested by the branch logic.
    typedef enum logic [1:0] {C_ALWAYS, C_IND, C_NEG, C_ZERO} cond_e;

    // Next-address source selection.
    typedef enum logic [1:0] {B_JUMP, B_CALL, B_RETURN, B_MAP} br_e;

    typedef struct packed {
        f1_e              f1;
        f2_e              f2;
        f3_e              f3;
        cond_e            cd;
        br_e              br;
        logic [CA_W-1:0]  ad;
    } uword_t;

endpackage

// File: rtl/ucpu_ctrl_rom.sv
// Control store: 128 microwords computed from a case on the address.
// Assumes routines for opcodes 0..3 at 4-word slots, fetch at 64, indirect at 67.
// Unlisted words return to the fetch routine, so unused opcodes act as no-ops.
module ucpu_ctrl_rom
    import ucpu_pkg::*;
(
    input  logic [CA_W-1:0] addr_i,
    output uword_t          word_o
);

    function automatic uword_t mk(input f1_e a, input f2_e b, input f3_e c,
                                  input cond_e d, input br_e e,
                                  input logic [CA_W-1:0] t);
        uword_t w;
        w.f1 = a;
        w.f2 = b;
        w.f3 = c;
        w.cd = d;
        w.br = e;
        w.ad = t;
        return w;
    endfunction

    // Microprogram contents, decoded from the control address.
    always_comb begin
        case (int'(addr_i))
            // ADD routine
            0:  word_o = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, INDIR_ENTRY);
            1:  word_o = mk(F1_NONE, F2_LOAD, F3_NONE, C_ALWAYS, B_JUMP, CA_W'(2));
            2:  word_o = mk(F1_SUM, F2_NONE, F3_NONE, C_ALWAYS, B_JUMP, FETCH_ENTRY);
            // BRANCH routine
            4:  word_o = mk(F1_NONE, F2_NONE, F3_NONE, C_NEG, B_JUMP, CA_W'(6));
            5:  word_o = mk(F1_NONE, F2_NONE, F3_NONE, C_ALWAYS, B_JUMP, FETCH_ENTRY);
            6:  word_o = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, INDIR_ENTRY);
            7:  word_o = mk(F1_NONE, F2_NONE, F3_AR_TO_PC, C_ALWAYS, B_JUMP, FETCH_ENTRY);
            // STORE routine
            8:  word_o = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, INDIR_ENTRY);
            9:  word_o = mk(F1_NONE, F2_AC_TO_DR, F3_NONE, C_ALWAYS, B_JUMP, CA_W'(10));
            10: word_o = mk(F1_STORE, F2_NONE, F3_NONE, C_ALWAYS, B_JUMP, FETCH_ENTRY);
            // EXCHANGE routine
            12: word_o = mk(F1_NONE, F2_NONE, F3_NONE, C_IND, B_CALL, INDIR_ENTRY);
            13: word_o = mk(F1_NONE, F2_LOAD, F3_NONE, C_ALWAYS, B_JUMP, CA_W'(14));
            14: word_o = mk(F1_DR_TO_AC, F2_AC_TO_DR, F3_NONE, C_ALWAYS, B_JUMP, CA_W'(15));
            15: word_o = mk(F1_STORE, F2_NONE, F3_NONE, C_ALWAYS, B_JUMP, FETCH_ENTRY);
            // Fetch subroutine
            64: word_o = mk(F1_PC_TO_AR, F2_NONE, F3_NONE, C_ALWAYS, B_JUMP, CA_W'(65));
            65: word_o = mk(F1_NONE, F2_LOAD, F3_INC_PC, C_ALWAYS, B_JUMP, CA_W'(66));
            66: word_o = mk(F1_DR_TO_AR, F2_NONE, F3_NONE, C_ALWAYS, B_MAP, '0);
            // Indirect-address subroutine
            67: word_o = mk(F1_NONE, F2_LOAD, F3_NONE, C_ALWAYS, B_JUMP, CA_W'(68));
            68: word_o = mk(F1_DR_TO_AR, F2_NONE, F3_NONE, C_ALWAYS, B_RETURN, '0);
            default: word_o = mk(F1_NONE, F2_NONE, F3_NONE, C_ALWAYS, B_JUMP, FETCH_ENTRY);
        endcase
    end

endmodule

// File: rtl/ucpu_sequencer.sv
// Next-address generator with control address, return register and control
// data register. Assumes the control store is combinational and addressed by
// next_addr_o, so the control data register always holds the word at car_o.
module ucpu_sequencer
    import ucpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ind_i,
    input  logic              neg_i,
    input  logic              zero_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  uword_t            rom_i,
    output logic [CA_W-1:0]   next_addr_o,
    output logic [CA_W-1:0]   car_o,
    output uword_t            cdr_o
);

    localparam int MAP_PAD = CA_W - OPC_W - 2;

    logic [CA_W-1:0] car_q;
    logic [CA_W-1:0] sbr_q;
    logic [CA_W-1:0] inc_addr;
    logic [CA_W-1:0] map_addr;
    logic [CA_W-1:0] next_addr;
    logic            hit;
    uword_t          cdr_q;

    assign inc_addr = car_q + 1'b1;
    assign map_addr = {{MAP_PAD{1'b0}}, opcode_i, 2'b00};

    // Status bit selected by the condition field.
    always_comb begin
        case (cdr_q.cd)
            C_ALWAYS: hit = 1'b1;
            C_IND:    hit = ind_i;
            C_NEG:    hit = neg_i;
            default:  hit = zero_i;
        endcase
    end

    // Next control address by branch type.
    always_comb begin
        case (cdr_q.br)
            B_JUMP, B_CALL: next_addr = hit ? cdr_q.ad : inc_addr;
            B_RETURN:       next_addr = sbr_q;
            default:        next_addr = map_addr;
        endcase
    end

    assign next_addr_o = rst_n ? next_addr : FETCH_ENTRY;

    // Control address and return register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q <= FETCH_ENTRY;
            sbr_q <= '0;
        end else begin
            car_q <= next_addr;
            if (cdr_q.br == B_CALL && hit) begin
                sbr_q <= inc_addr;
            end
        end
    end

    // Control data register: captures the word for the address just formed.
    always_ff @(posedge clk) begin
        cdr_q <= rom_i;
    end

    assign car_o = car_q;
    assign cdr_o = cdr_q;

    p_call_link_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cdr_q.br == B_CALL && hit) |=> (sbr_q == $past(car_q) + 1'b1));

    p_return_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cdr_q.br == B_RETURN) |=> (car_q == $past(sbr_q)));

    p_map_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cdr_q.br == B_MAP) |=> (car_q[CA_W-1] == 1'b0 && car_q[1:0] == 2'b00));

endmodule

// File: rtl/ucpu_alu.sv
// Accumulator next-value logic for the three micro-operation fields.
// Assumes the microprogram never asks two fields for an AC change at once;
// if it does, the first field wins over the second, the second over the third.
module ucpu_alu
    import ucpu_pkg::*;
(
    input  logic [WORD_W-1:0] ac_i,
    input  logic [WORD_W-1:0] dr_i,
    input  f1_e               f1_i,
    input  f2_e               f2_i,
    input  f3_e               f3_i,
    output logic [WORD_W-1:0] ac_o
);

    // Layered selection: third field, then second, then first overrides.
    always_comb begin
        ac_o = ac_i;
        case (f3_i)
            F3_XOR:  ac_o = ac_i ^ dr_i;
            F3_INV:  ac_o = ~ac_i;
            F3_SHL:  ac_o = ac_i << 1;
            F3_SHR:  ac_o = ac_i >> 1;
            default: ;
        endcase
        case (f2_i)
            F2_DIFF: ac_o = ac_i - dr_i;
            F2_OR:   ac_o = ac_i | dr_i;
            F2_AND:  ac_o = ac_i & dr_i;
            default: ;
        endcase
        case (f1_i)
            F1_SUM:      ac_o = ac_i + dr_i;
            F1_ZERO_AC:  ac_o = '0;
            F1_INC_AC:   ac_o = ac_i + 1'b1;
            F1_DR_TO_AC: ac_o = dr_i;
            default: ;
        endcase
    end

endmodule

// File: rtl/ucpu_datapath.sv
// Register file (AC, DR, AR, PC) and main memory driven by the current microword.
// Assumes memory reads go only to DR, writes come only from DR, AR loads from
// PC or DR, and PC loads only from AR or by increment. Preload wins over writes.
module ucpu_datapath
    import ucpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  uword_t            uw_i,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    output logic [WORD_W-1:0] ac_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              ind_o,
    output logic              neg_o,
    output logic              zero_o,
    output logic [OPC_W-1:0]  opcode_o
);

    logic [WORD_W-1:0] mem [MEM_WORDS];
    logic [WORD_W-1:0] ac_q, dr_q, ac_next, rd_data;
    logic [ADDR_W-1:0] ar_q, pc_q;

    assign rd_data = mem[ar_q];

    ucpu_alu i_alu (
        .ac_i (ac_q),
        .dr_i (dr_q),
        .f1_i (uw_i.f1),
        .f2_i (uw_i.f2),
        .f3_i (uw_i.f3),
        .ac_o (ac_next)
    );

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_next;
    end

    // Data register: memory read, AC copy, increment or PC copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else begin
            case (uw_i.f2)
                F2_LOAD:     dr_q <= rd_data;
                F2_AC_TO_DR: dr_q <= ac_q;
                F2_INC_DR:   dr_q <= dr_q + 1'b1;
                F2_PC_TO_DR: dr_q <= WORD_W'(pc_q);
                default: ;
            endcase
        end
    end

    // Address register: loads from DR address bits or from PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '0;
        end else if (uw_i.f1 == F1_DR_TO_AR) begin
            ar_q <= dr_q[ADDR_W-1:0];
        end else if (uw_i.f1 == F1_PC_TO_AR) begin
            ar_q <= pc_q;
        end
    end

    // Program counter: increment or load from AR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (uw_i.f3 == F3_INC_PC) begin
            pc_q <= pc_q + 1'b1;
        end else if (uw_i.f3 == F3_AR_TO_PC) begin
            pc_q <= ar_q;
        end
    end

    // Main memory write: preload port first, then microcode store of DR.
    always_ff @(posedge clk) begin
        if (pre_we) begin
            mem[pre_addr] <= pre_data;
        end else if (rst_n && uw_i.f1 == F1_STORE) begin
            mem[ar_q] <= dr_q;
        end
    end

    assign ac_o     = ac_q;
    assign pc_o     = pc_q;
    assign ind_o    = dr_q[WORD_W-1];
    assign neg_o    = ac_q[WORD_W-1];
    assign zero_o   = (ac_q == '0);
    assign opcode_o = dr_q[OPC_LSB +: OPC_W];

    p_pc_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + 1'b1 || pc_q == $past(ar_q)));

    p_ar_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_q != $past(ar_q)) |-> (ar_q == $past(pc_q) || ar_q == $past(dr_q[ADDR_W-1:0])));

endmodule

// File: rtl/ucode_accum_cpu.sv
// Top of the microprogrammed accumulator processor: control store, sequencer
// and datapath. Assumes memory is preloaded while rst_n is held low.
module ucode_accum_cpu
    import ucpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    output logic [WORD_W-1:0] ac_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [CA_W-1:0]   car_o
);

    logic [CA_W-1:0]  next_addr;
    uword_t           rom_word;
    uword_t           cur_word;
    logic             ind, neg, zero;
    logic [OPC_W-1:0] opcode;

    ucpu_ctrl_rom i_rom (
        .addr_i (next_addr),
        .word_o (rom_word)
    );

    ucpu_sequencer i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ind_i       (ind),
        .neg_i       (neg),
        .zero_i      (zero),
        .opcode_i    (opcode),
        .rom_i       (rom_word),
        .next_addr_o (next_addr),
        .car_o       (car_o),
        .cdr_o       (cur_word)
    );

    ucpu_datapath i_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .uw_i     (cur_word),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .ac_o     (ac_o),
        .pc_o     (pc_o),
        .ind_o    (ind),
        .neg_o    (neg),
        .zero_o   (zero),
        .opcode_o (opcode)
    );

endmodule

// File: tb/test_ucode_accum_cpu.sv
`timescale 1ns/1ps
module test_ucode_accum_cpu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_we = 1'b0;
    logic [10:0] pre_addr = '0;
    logic [15:0] pre_data = '0;
    logic [15:0] ac_o;
    logic [10:0] pc_o;
    logic [6:0]  car_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ucode_accum_cpu i_ucode_accum_cpu (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .ac_o(ac_o), .pc_o(pc_o), .car_o(car_o)
    );

    function automatic logic [15:0] ins(input logic ind, input logic [3:0] op,
                                        input logic [10:0] a);
        return {ind, op, a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [10:0] a, input logic [15:0] d);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic release_cpu();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Cycles until the next fetch start (control address 64).
    task automatic next_fetch(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (car_o != 7'd64 && cyc < 60);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [15:0] sum, v, a_val, y_val;
        hold_reset();
        // R1: reset state
        chk("R1 reset ac", ac_o, 0);
        chk("R1 reset pc", pc_o, 0);
        chk("R1 reset car", car_o, 64);
        // R11: preload clears memory
        for (int i = 0; i < 2048; i++) poke(11'(i), 16'h0000);

        // ADD sweep, every third instruction indirect (R3, R4, R2)
        for (int k = 0; k < 40; k++) begin
            logic ind;
            ind = (k % 3 == 2);
            poke(11'(k), ins(ind, 4'd0, ind ? 11'(16'h600 + k) : 11'(16'h400 + k)));
            poke(11'(16'h400 + k), 16'(k * 16'h1357 + 16'h0F0F));
            poke(11'(16'h600 + k), {5'b10110, 11'(16'h400 + k)});
        end
        release_cpu();
        sum = 0;
        for (int k = 0; k < 40; k++) begin
            logic ind;
            ind = (k % 3 == 2);
            next_fetch(cyc);
            sum = sum + 16'(k * 16'h1357 + 16'h0F0F);
            chk(ind ? "R4 R9 R10 indirect add cycles" : "R10 add cycles", cyc, ind ? 8 : 6);
            chk(ind ? "R4 R3 indirect add ac" : "R2 R3 add ac", ac_o, sum);
            chk("R3 pc advance", pc_o, 11'(k + 1));
        end

        // BRANCH sweep over sign values and indirection (R5)
        for (int k = 0; k < 16; k++) begin
            logic ind, neg;
            logic [10:0] tgt;
            case (k % 4)
                0: v = 16'h8000;
                1: v = 16'h7FFF;
                2: v = 16'hFFFF;
                default: v = 16'h0000;
            endcase
            ind = k[2];
            neg = v[15];
            tgt = 11'(16'h100 + k * 3);
            hold_reset();
            poke(11'd0, ins(1'b0, 4'd0, 11'h700));
            poke(11'h700, v);
            poke(11'd1, ins(ind, 4'd1, ind ? 11'h710 : tgt));
            poke(11'h710, {5'b11111, tgt});
            release_cpu();
            next_fetch(cyc);
            next_fetch(cyc);
            chk("R5 R10 branch cycles", cyc, neg ? (ind ? 8 : 6) : 5);
            chk("R5 branch pc", pc_o, neg ? tgt : 11'd2);
            chk("R5 branch keeps ac", ac_o, v);
        end

        // STORE then EXCHANGE round trip (R6, R7)
        for (int k = 0; k < 8; k++) begin
            logic ind;
            logic [10:0] x, ea;
            ind = k[0];
            x = 11'(16'h480 + k);
            ea = ind ? 11'(16'h500 + k) : x;
            a_val = 16'(k * 16'h2468 + 16'h8001);
            y_val = 16'(k * 16'h0777 + 1);
            hold_reset();
            poke(11'(16'h580 + k), a_val);
            poke(11'(16'h5C0 + k), y_val);
            poke(x, 16'hDEAD ^ 16'(k));
            poke(11'(16'h500 + k), {5'b01010, x});
            poke(11'd0, ins(1'b0, 4'd0, 11'(16'h580 + k)));
            poke(11'd1, ins(ind, 4'd2, ea));
            poke(11'd2, ins(1'b0, 4'd0, 11'(16'h5C0 + k)));
            poke(11'd3, ins(ind, 4'd3, ea));
            poke(11'd4, ins(ind, 4'd3, ea));
            release_cpu();
            next_fetch(cyc);
            next_fetch(cyc);
            chk("R6 R10 store cycles", cyc, ind ? 8 : 6);
            chk("R6 store keeps ac", ac_o, a_val);
            next_fetch(cyc);
            next_fetch(cyc);
            chk("R7 R10 exchange cycles", cyc, ind ? 9 : 7);
            chk("R6 R7 exchange returns stored value", ac_o, a_val);
            next_fetch(cyc);
            chk("R7 exchange returns written-back ac", ac_o, 16'(a_val + y_val));
            chk("R7 pc after exchanges", pc_o, 11'd5);
        end

        // Unimplemented opcodes 4..15 with both indirect settings (R8)
        hold_reset();
        poke(11'h7F0, 16'h1234);
        poke(11'd0, ins(1'b0, 4'd0, 11'h7F0));
        for (int j = 0; j < 24; j++) begin
            poke(11'(j + 1), ins(j[0], 4'(4 + j / 2), 11'h7F0));
        end
        poke(11'd25, ins(1'b0, 4'd3, 11'h7F0));
        poke(11'd26, ins(1'b0, 4'd3, 11'h7F0));
        release_cpu();
        next_fetch(cyc);
        for (int j = 0; j < 24; j++) begin
            next_fetch(cyc);
            chk("R8 R10 unused opcode cycles", cyc, 4);
            chk("R8 unused opcode keeps ac", ac_o, 16'h1234);
            chk("R8 unused opcode pc", pc_o, 11'(j + 2));
        end
        next_fetch(cyc);
        chk("R8 memory untouched by unused opcodes", ac_o, 16'h1234);
        next_fetch(cyc);
        chk("R7 R8 exchange back", ac_o, 16'h1234);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule